// File: doc/BRIEF.md
# Fully Associative Multi-Page-Size Translation Buffer

This block translates virtual addresses through a 64-entry, fully associative buffer. Every entry has a virtual tag, a 13-bit context and an attribute word. The attribute word carries the physical page number, a page-size code, and the global, writable, privileged, side-effect, no-fault-only and used flags. Each entry applies its own compare mask, chosen by its size code, so 8 KB, 64 KB, 512 KB and 4 MB pages can share the buffer. All entries are compared in the same cycle and the lowest-index match is taken.

A lookup presents a virtual address, a context selector and the access kind: write, user mode and non-faulting load. One cycle later the block reports exactly one result: hit, miss, protection fault or access fault. On a hit it also gives a 41-bit physical address. Faults load a status word, a fault-address register and a tag-access register. Misses load only the tag-access register. A clean hit sets the entry's used flag. When translation is off, addresses pass through truncated to 41 bits. Software fills entries through a write port, reads them back through a read port, and clears the status word with a strobe.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, all entries are invalid, read back as zero, and all result flags, the fault status, the fault address and the tag access are zero.
- R2: A write with `wrEn` stores `wrVa`, `wrCtx` and `wrWord` into entry `wrIdx`. The `wrWord` layout is: bit 0 global, bit 1 writable, bit 2 privileged, bit 3 side-effect, bit 4 no-fault-only, bit 5 used, bits 7:6 size code, bits 40:13 physical page, bit 63 valid. An entry with bit 63 clear never hits.
- R3: The size code sets the compared virtual bits: code 0 compares 63:13, code 1 compares 63:16, code 2 compares 63:19 and code 3 compares 63:22.
- R4: An entry matches only if it is global or its context equals the lookup context. The lookup context is `priCtx` for selector 0, `secCtx` for selector 1 and zero for selector 2 (nucleus).
- R5: When several entries match, the lowest-index entry supplies the result.
- R6: On a hit, physical bits 40:13 come from the entry's page where the mask compares and from the virtual address elsewhere. Bits 12:0 are the virtual offset.
- R7: An access fault is raised on a hit in three cases: a user access to a privileged entry, a non-faulting load to a side-effect entry, or a normal access to a no-fault-only entry.
- R8: A write that hits a non-writable entry, with no access fault, raises a protection fault.
- R9: Any fault loads `faultStatus`. The layout is: bit 0 valid, bit 1 overwrite, bit 2 write, bit 3 privileged state, bits 5:4 selector. Bits 9:6 are fault type: bit 6 privilege, bit 7 side-effect, bit 8 no-fault-only, bit 9 protection. Overwrite is set if the old status was valid and `statusClr` is low that cycle. `statusClr` alone zeroes the status.
- R10: A fault loads `faultAddr` with the virtual address. A miss or a fault loads `tagAccess` with the virtual address bits 63:13 above the 13-bit lookup context. A miss leaves `faultStatus` and `faultAddr` unchanged.
- R11: A clean hit sets the used flag (bit 5) of the winning entry. Entries that do not win are left unchanged.
- R12: With `xlatEn` low, a request always hits with `respPa` equal to virtual bits 40:0. No fault register changes.
- R13: Results appear in the cycle after the request, with `respValid` high and exactly one of hit, miss, protection fault or access fault. With no request, all result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlatEn | input | 1 | Translation enable |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 6 | Entry index to write |
| wrVa | input | 64 | Virtual tag to store (bits 63:13 kept) |
| wrCtx | input | 13 | Context to store |
| wrWord | input | 64 | Attribute word to store |
| rdIdx | input | 6 | Entry index to read back |
| rdWord | output | 64 | Attribute word of entry `rdIdx` |
| priCtx | input | 13 | Primary context |
| secCtx | input | 13 | Secondary context |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 64 | Virtual address of the lookup |
| reqCtxSel | input | 2 | Context selector: 0 primary, 1 secondary, 2 nucleus |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user mode |
| reqPriv | input | 1 | Processor privileged state, recorded on fault |
| reqNfLoad | input | 1 | Access is a non-faulting load |
| statusClr | input | 1 | Clear fault status |
| respValid | output | 1 | Result valid |
| respHit | output | 1 | Translation succeeded |
| respMiss | output | 1 | No entry matched |
| respProt | output | 1 | Protection fault |
| respFault | output | 1 | Access fault |
| respPa | output | 41 | Physical address |
| faultStatus | output | 10 | Fault status word |
| faultAddr | output | 64 | Faulting virtual address |
| tagAccess | output | 64 | Page address and context of the last miss or fault |

## Verification
A fault and a status clear can arrive in the same cycle. The status is then rewritten with valid set and overwrite clear, because the clear counts as a read of the old status. The bench provokes this with a side-effect fault issued together with `statusClr`. It checks the whole status word against a value derived from the field layout, and it also checks that an earlier fault without a clear set the overwrite bit. A miss follows, and the bench checks that it changes only the tag-access register.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  // attribute word field positions (software-visible layout)
  localparam int W_GLOBAL   = 0;
  localparam int W_WRITABLE = 1;
  localparam int W_PRIV     = 2;
  localparam int W_SIDEEFF  = 3;
  localparam int W_NFO      = 4;
  localparam int W_USED     = 5;
  localparam int W_SIZE_LO  = 6;
  localparam int W_VALID    = 63;

  typedef enum logic [1:0] {
    CTX_PRIMARY   = 2'd0,
    CTX_SECONDARY = 2'd1,
    CTX_NUCLEUS   = 2'd2
  } ctxSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic markUsed;
    logic loadPa;
    logic bypass;
  } dpStrobe_t;
endpackage

// File: rtl/xlat_tlb_dp.sv
module xlat_tlb_dp
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 64,
  parameter int PA_W       = 41,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int SIZE_STEP  = 3,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = VA_W - PAGE_SHIFT,
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic [63:0]      wrWord,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [63:0]      rdWord,
  input  logic [VA_W-1:0]  lookVa,
  input  logic [CTX_W-1:0] lookCtx,
  input  dpStrobe_t        strobe,
  output logic             anyHit,
  output logic [3:0]       hitAttr,
  output logic [PA_W-1:0]  respPa
);
  logic [TAG_W-1:0] tagVa  [ENTRIES];
  logic [CTX_W-1:0] tagCtx [ENTRIES];
  logic [63:0]      word   [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0] hitIdx;
  logic [63:0]      hitWord;
  logic [PPN_W-1:0] ppnMask, composedPpn;

  function automatic logic [TAG_W-1:0] tagMask(input logic [1:0] sz);
    logic [TAG_W-1:0] m;
    for (int b = 0; b < TAG_W; b++) m[b] = (b >= SIZE_STEP * int'(sz));
    return m;
  endfunction

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic [TAG_W-1:0] cmpMask;
      assign cmpMask = tagMask(word[e][W_SIZE_LO+1:W_SIZE_LO]);
      assign matchVec[e] = word[e][W_VALID]
        && (((tagVa[e] ^ lookVa[VA_W-1:PAGE_SHIFT]) & cmpMask) == '0)
        && (word[e][W_GLOBAL] || (tagCtx[e] == lookCtx));
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  assign anyHit  = |matchVec;
  assign hitWord = word[hitIdx];
  assign hitAttr = hitWord[W_NFO:W_WRITABLE];
  assign rdWord  = word[rdIdx];

  assign ppnMask = PPN_W'(tagMask(hitWord[W_SIZE_LO+1:W_SIZE_LO]));
  assign composedPpn = (hitWord[PA_W-1:PAGE_SHIFT] & ppnMask)
                     | (lookVa[PA_W-1:PAGE_SHIFT] & ~ppnMask);

  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagVa[wrIdx]  <= wrTag;
      tagCtx[wrIdx] <= wrCtx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) word[i] <= '0;
      respPa <= '0;
    end else begin
      if (wrEn) word[wrIdx] <= wrWord;
      if (strobe.markUsed && !(wrEn && wrIdx == hitIdx))
        word[hitIdx][W_USED] <= 1'b1;
      if (strobe.loadPa)
        respPa <= strobe.bypass ? lookVa[PA_W-1:0]
                                : {composedPpn, lookVa[PAGE_SHIFT-1:0]};
    end
  end

  // R11
  used_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markUsed && !(wrEn && wrIdx == hitIdx)) |=> word[$past(hitIdx)][W_USED]);
endmodule

// File: rtl/xlat_tlb_ctl.sv
module xlat_tlb_ctl
  import xlat_tlb_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlatEn,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqCtxSel,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic             reqPriv,
  input  logic             reqNfLoad,
  input  logic             statusClr,
  input  logic [CTX_W-1:0] priCtx,
  input  logic [CTX_W-1:0] secCtx,
  input  logic             anyHit,
  input  logic [3:0]       hitAttr,
  output logic [CTX_W-1:0] lookCtx,
  output dpStrobe_t        strobe,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             respProt,
  output logic             respFault,
  output logic [9:0]       faultStatus,
  output logic [VA_W-1:0]  faultAddr,
  output logic [VA_W-1:0]  tagAccess
);
  logic live, ftPriv, ftSe, ftNfo, accErr, protErr, missErr, clean, faulting;
  logic [3:0] newFt;

  always_comb begin
    case (ctxSel_e'(reqCtxSel))
      CTX_PRIMARY:   lookCtx = priCtx;
      CTX_SECONDARY: lookCtx = secCtx;
      default:       lookCtx = '0;
    endcase
  end

  // hitAttr = {nfo, sideEffect, priv, writable}
  assign live     = reqValid && xlatEn;
  assign ftPriv   = hitAttr[1] && reqUser;
  assign ftSe     = hitAttr[2] && reqNfLoad;
  assign ftNfo    = hitAttr[3] && !reqNfLoad;
  assign accErr   = live && anyHit && (ftPriv || ftSe || ftNfo);
  assign protErr  = live && anyHit && !accErr && reqWrite && !hitAttr[0];
  assign missErr  = live && !anyHit;
  assign clean    = live && anyHit && !accErr && !protErr;
  assign faulting = accErr || protErr;
  assign newFt    = accErr ? {1'b0, ftNfo, ftSe, ftPriv} : 4'b1000;

  assign strobe.markUsed = clean;
  assign strobe.loadPa   = clean || (reqValid && !xlatEn);
  assign strobe.bypass   = !xlatEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respMiss    <= 1'b0;
      respProt    <= 1'b0;
      respFault   <= 1'b0;
      faultStatus <= '0;
      faultAddr   <= '0;
      tagAccess   <= '0;
    end else begin
      respValid <= reqValid;
      respHit   <= clean || (reqValid && !xlatEn);
      respMiss  <= missErr;
      respProt  <= protErr;
      respFault <= accErr;
      if (faulting) begin
        faultStatus <= {newFt, reqCtxSel, reqPriv, reqWrite,
                        faultStatus[0] && !statusClr, 1'b1};
        faultAddr   <= reqVa;
      end else if (statusClr) begin
        faultStatus <= '0;
      end
      if (faulting || missErr)
        tagAccess <= {reqVa[VA_W-1:PAGE_SHIFT], lookCtx};
    end
  end

  // R13
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respHit, respMiss, respProt, respFault}));
  // R13
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid && (respHit || respMiss || respProt || respFault));
  // R9
  fault_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    faulting |=> faultStatus[0] && faultAddr == $past(reqVa));
  // R9
  overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faulting && faultStatus[0] && !statusClr) |=> faultStatus[1]);
  // R10
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missErr && !statusClr) |=> $stable(faultStatus) && $stable(faultAddr)
      && tagAccess[CTX_W-1:0] == $past(lookCtx));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 64,
  parameter int PA_W       = 41,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int SIZE_STEP  = 3,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlatEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VA_W-1:0]  wrVa,
  input  logic [CTX_W-1:0] wrCtx,
  input  logic [63:0]      wrWord,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [63:0]      rdWord,
  input  logic [CTX_W-1:0] priCtx,
  input  logic [CTX_W-1:0] secCtx,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqCtxSel,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic             reqPriv,
  input  logic             reqNfLoad,
  input  logic             statusClr,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             respProt,
  output logic             respFault,
  output logic [PA_W-1:0]  respPa,
  output logic [9:0]       faultStatus,
  output logic [VA_W-1:0]  faultAddr,
  output logic [VA_W-1:0]  tagAccess
);
  dpStrobe_t        strobe;
  logic             anyHit;
  logic [3:0]       hitAttr;
  logic [CTX_W-1:0] lookCtx;

  xlat_tlb_dp #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W),
    .PAGE_SHIFT(PAGE_SHIFT), .SIZE_STEP(SIZE_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrVa[VA_W-1:PAGE_SHIFT]),
    .wrCtx(wrCtx), .wrWord(wrWord),
    .rdIdx(rdIdx), .rdWord(rdWord),
    .lookVa(reqVa), .lookCtx(lookCtx), .strobe(strobe),
    .anyHit(anyHit), .hitAttr(hitAttr), .respPa(respPa)
  );

  xlat_tlb_ctl #(
    .VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .xlatEn(xlatEn),
    .reqValid(reqValid), .reqVa(reqVa), .reqCtxSel(reqCtxSel),
    .reqWrite(reqWrite), .reqUser(reqUser), .reqPriv(reqPriv),
    .reqNfLoad(reqNfLoad), .statusClr(statusClr),
    .priCtx(priCtx), .secCtx(secCtx),
    .anyHit(anyHit), .hitAttr(hitAttr),
    .lookCtx(lookCtx), .strobe(strobe),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respProt(respProt), .respFault(respFault),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .tagAccess(tagAccess)
  );
endmodule

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xlatEn = 1'b1;
  logic wrEn = 1'b0;
  logic [5:0] wrIdx = '0, rdIdx = '0;
  logic [63:0] wrVa = '0, wrWord = '0, reqVa = '0;
  logic [12:0] wrCtx = '0;
  logic [12:0] priCtx = 13'd5, secCtx = 13'd9;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0, reqPriv = 1'b0;
  logic reqNfLoad = 1'b0, statusClr = 1'b0;
  logic [1:0] reqCtxSel = '0;
  logic [63:0] rdWord, faultAddr, tagAccess;
  logic respValid, respHit, respMiss, respProt, respFault;
  logic [40:0] respPa;
  logic [9:0] faultStatus;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  xlat_tlb u0 (
    .clk(clk), .rstN(rstN), .xlatEn(xlatEn),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVa(wrVa), .wrCtx(wrCtx), .wrWord(wrWord),
    .rdIdx(rdIdx), .rdWord(rdWord), .priCtx(priCtx), .secCtx(secCtx),
    .reqValid(reqValid), .reqVa(reqVa), .reqCtxSel(reqCtxSel),
    .reqWrite(reqWrite), .reqUser(reqUser), .reqPriv(reqPriv),
    .reqNfLoad(reqNfLoad), .statusClr(statusClr),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respProt(respProt), .respFault(respFault), .respPa(respPa),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .tagAccess(tagAccess)
  );

  // result code {hit, miss, prot, fault}
  localparam logic [3:0] HIT = 4'b1000, MISS = 4'b0100, PROT = 4'b0010, FLT = 4'b0001;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic        usr;
    logic        nf;
    logic [1:0]  sel;
    logic [3:0]  res;
    logic [40:0] pa;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0055_5000, 1'b0, 1'b0, 1'b0, 2'd0, HIT,  41'h0_8015_5000, 8'd3}, // R3 R6 4MB
    '{64'h0080_0000, 1'b0, 1'b0, 1'b0, 2'd0, MISS, 41'h0,           8'd3}, // R3
    '{64'h1000_0ABC, 1'b0, 1'b0, 1'b0, 2'd0, HIT,  41'h1_0000_2ABC, 8'd5}, // R5 global idx1 over idx5
    '{64'h1000_0ABC, 1'b1, 1'b0, 1'b0, 2'd0, PROT, 41'h0,           8'd8}, // R8
    '{64'h2000_1234, 1'b0, 1'b1, 1'b0, 2'd0, FLT,  41'h0,           8'd7}, // R7 priv
    '{64'h2000_1234, 1'b1, 1'b0, 1'b0, 2'd0, HIT,  41'h0_3000_1234, 8'd6}, // R6 64KB
    '{64'h2001_0000, 1'b0, 1'b0, 1'b0, 2'd0, MISS, 41'h0,           8'd3}, // R3
    '{64'h3007_FFF0, 1'b0, 1'b0, 1'b0, 2'd1, HIT,  41'h0_400F_FFF0, 8'd4}, // R4 secondary
    '{64'h3007_FFF0, 1'b0, 1'b0, 1'b0, 2'd0, MISS, 41'h0,           8'd4}, // R4
    '{64'h6000_0010, 1'b0, 1'b0, 1'b0, 2'd2, HIT,  41'h0_6000_0010, 8'd7}, // R7 nucleus
    '{64'h6000_0010, 1'b0, 1'b0, 1'b1, 2'd2, FLT,  41'h0,           8'd7}, // R7 side-effect
    '{64'h7000_0020, 1'b0, 1'b0, 1'b0, 2'd2, FLT,  41'h0,           8'd7}, // R7 nfo
    '{64'h7000_0020, 1'b0, 1'b0, 1'b1, 2'd2, HIT,  41'h0_7100_0020, 8'd7}, // R7
    '{64'h8000_0000, 1'b0, 1'b0, 1'b0, 2'd0, MISS, 41'h0,           8'd2}, // R2 invalid
    '{64'h9000_0000, 1'b0, 1'b0, 1'b0, 2'd0, MISS, 41'h0,           8'd4}, // R4 ctx mismatch
    '{64'h9000_0000, 1'b0, 1'b0, 1'b0, 2'd2, MISS, 41'h0,           8'd4}  // R4
  };

  function automatic logic [63:0] mk(input logic v, input logic [1:0] sz,
      input logic [40:0] pa, input logic g, w, p, se, nfo);
    logic [63:0] x = '0;
    x[63] = v; x[7:6] = sz; x[40:13] = pa[40:13];
    x[0] = g; x[1] = w; x[2] = p; x[3] = se; x[4] = nfo;
    return x;
  endfunction

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] va, input logic [12:0] ctx,
      input logic [63:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(idx); wrVa = va; wrCtx = ctx; wrWord = w;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic w, u, nf,
      input logic [1:0] sel, input logic prv, input logic clr);
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqWrite = w; reqUser = u; reqNfLoad = nf;
    reqCtxSel = sel; reqPriv = prv; statusClr = clr;
    @(posedge clk); #1;
    reqValid = 1'b0; statusClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({59'd0, respValid, respHit, respMiss, respProt, respFault}, 64'd0, "R1 flags");
    chk({54'd0, faultStatus}, 64'd0, "R1 status");
    chk(tagAccess, 64'd0, "R1 tagAccess");
    chk(rdWord, 64'd0, "R1 entry0");
    @(negedge clk); rstN = 1'b1;

    wr(0, 64'h0040_0000, 13'd5, mk(1, 2'd3, 41'h0_8000_0000, 0, 1, 0, 0, 0));
    wr(1, 64'h1000_0000, 13'd7, mk(1, 2'd0, 41'h1_0000_2000, 1, 0, 0, 0, 0));
    wr(2, 64'h2000_0000, 13'd5, mk(1, 2'd1, 41'h0_3000_0000, 0, 1, 1, 0, 0));
    wr(3, 64'h3000_0000, 13'd9, mk(1, 2'd2, 41'h0_4008_0000, 0, 1, 0, 0, 0));
    wr(5, 64'h1000_0000, 13'd5, mk(1, 2'd0, 41'h0_5000_0000, 0, 1, 0, 0, 0));
    wr(6, 64'h6000_0000, 13'd0, mk(1, 2'd0, 41'h0_6000_0000, 0, 1, 0, 1, 0));
    wr(7, 64'h7000_0000, 13'd0, mk(1, 2'd0, 41'h0_7100_0000, 0, 1, 0, 0, 1));
    wr(8, 64'h8000_0000, 13'd5, mk(0, 2'd0, 41'h0_8000_0000, 0, 1, 0, 0, 0));
    wr(9, 64'h9000_0000, 13'd6, mk(1, 2'd0, 41'h0_9000_0000, 0, 1, 0, 0, 0));
    rdIdx = 6'd2; #1;
    chk(rdWord, mk(1, 2'd1, 41'h0_3000_0000, 0, 1, 1, 0, 0), "R2 readback");

    for (int i = 0; i < NVEC; i++) begin
      look(VECS[i].va, VECS[i].wr, VECS[i].usr, VECS[i].nf, VECS[i].sel, 1'b0, 1'b0);
      checks++;
      if ({respHit, respMiss, respProt, respFault} !== VECS[i].res || respValid !== 1'b1) begin
        failures++;
        $display("FAIL R%0d vec%0d result got=%b exp=%b", VECS[i].req, i,
                 {respHit, respMiss, respProt, respFault}, VECS[i].res);
      end
      if (VECS[i].res == HIT) begin
        checks++;
        if (respPa !== VECS[i].pa) begin
          failures++;
          $display("FAIL R6 vec%0d pa got=%h exp=%h", i, respPa, VECS[i].pa);
        end
      end
    end

    // R13 idle: no result flags
    @(negedge clk); @(posedge clk); #1;
    chk({59'd0, respValid, respHit, respMiss, respProt, respFault}, 64'd0, "R13 idle");

    // R11 used flag on winners only; R5 shadowed entry untouched
    rdIdx = 6'd1; #1; chk({63'd0, rdWord[5]}, 64'd1, "R11 idx1 used");
    rdIdx = 6'd5; #1; chk({63'd0, rdWord[5]}, 64'd0, "R5 R11 idx5 unused");
    rdIdx = 6'd0; #1; chk({63'd0, rdWord[5]}, 64'd1, "R11 idx0 used");

    // R9 clear
    @(negedge clk); statusClr = 1'b1; @(posedge clk); #1; statusClr = 1'b0;
    chk({54'd0, faultStatus}, 64'd0, "R9 clear");
    // R9 R10 privilege fault
    look(64'h2000_1234, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    chk({54'd0, faultStatus}, 64'h041, "R9 priv status");
    chk(faultAddr, 64'h2000_1234, "R10 faultAddr");
    chk(tagAccess, 64'h2000_0005, "R10 tagAccess");
    // R9 overwrite with protection fault
    look(64'h1000_0ABC, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    chk({54'd0, faultStatus}, 64'h20F, "R9 overwrite");
    chk(tagAccess, 64'h1000_0005, "R10 tagAccess prot");
    // R9 fault and clear in one cycle
    look(64'h6000_0010, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
    chk({54'd0, faultStatus}, 64'h0A1, "R9 fault+clear");
    // R10 miss keeps status and address
    look(64'h9000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk({54'd0, faultStatus}, 64'h0A1, "R10 miss status");
    chk(faultAddr, 64'h6000_0010, "R10 miss faultAddr");
    chk(tagAccess, 64'h9000_0005, "R10 miss tagAccess");

    // R12 pass-through
    xlatEn = 1'b0;
    look(64'hFFFF_FFFF_FFFF_1234, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    chk({60'd0, respHit, respMiss, respProt, respFault}, 64'h8, "R12 hit");
    chk({23'd0, respPa}, 64'h1FF_FFFF_1234, "R12 pa");
    chk({54'd0, faultStatus}, 64'h0A1, "R12 status");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule